// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Burst SRAM

This block is a synthesizable model of a synchronous, pipelined burst memory whose data bus never idles when the traffic switches between reads and writes. Each enabled clock edge accepts one command: either a new address (load) or the next beat of the current burst (advance). For a read, the word appears on the output register two enabled edges after its address edge. For a write, the data is taken from the input bus on the second enabled edge after its address edge. Reads and writes therefore line up on the data bus in issue order and can be mixed freely on consecutive clocks.

Write data is first placed in a one-entry pending-write register. It is merged into the array, lane by lane, when the next write reaches its data phase. A read whose address matches the pending entry takes the written lanes from that register and the remaining lanes from the array. The word is built from LANES lanes of 9 bits each, and a per-lane select chooses which lanes a write changes.

Selection and bursts are handled by a small burst controller. It has three states: ST_IDLE (last load deselected), ST_READ (last load was a selected read) and ST_WRITE (last load was a selected write). A load moves the controller to one of these three states, according to the chip enables and the write enable. An advance keeps the current state and repeats its operation at the next beat address. A static input chooses linear or interleaved beat order, and both orders wrap within four beats.

Top module: `pipe_burst_sram`

## Requirements
- R1: A selected read loaded on enabled edge n puts the array word on dout after enabled edge n+2. dout_drive is then high while out_en is high.
- R2: A selected write loaded on enabled edge n takes din at enabled edge n+2. Later reads of that address return it.
- R3: A write changes only the lanes whose byte_sel bit is 1. Bit i covers dout/din bits [9i+8:9i], and byte_sel is sampled with the address.
- R4: A load selects the device only when sel0_n=0, sel1=1 and sel2_n=0. Any other combination performs no operation: nothing is written and dout_drive is low in that command's data phase.
- R5: With clk_en=0, no register changes and no command is accepted. dout holds its value and the pipeline resumes unchanged afterwards.
- R6: dout_drive is low whenever out_en is low, with no clock edge needed.
- R7: In the data phase of a write, dout_drive is low even when out_en is high.
- R8: Reads and writes in any mix on consecutive enabled clocks return the last data written. This includes a read of a write still in the pending register, which gets the new lanes merged with the old ones.
- R9: With burst_ilv=0, advance beat k uses low address bits (start+k) mod 4, and the upper bits are kept.
- R10: With burst_ilv=1, advance beat k uses low address bits start XOR k, and the upper bits are kept.
- R11: An advance repeats the operation type of the last load and ignores wr_en and the chip enables. After a deselected load, an advance is also a no-op.
- R12: After reset, dout is zero and dout_drive is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en | input | 1 | Clock qualifier; low freezes the block |
| addr | input | ADDR_W | Word address for a load |
| adv_load | input | 1 | 1 = advance burst, 0 = load new address |
| wr_en | input | 1 | 1 = write, 0 = read (on a load) |
| byte_sel | input | LANES | Per-lane write selects |
| sel0_n | input | 1 | Chip enable, active low |
| sel1 | input | 1 | Chip enable, active high |
| sel2_n | input | 1 | Chip enable, active low |
| burst_ilv | input | 1 | Static beat order: 0 linear, 1 interleaved |
| out_en | input | 1 | Asynchronous output enable |
| din | input | 9*LANES | Write data bus |
| dout | output | 9*LANES | Registered read data |
| dout_drive | output | 1 | Output drive flag |

## Verification
The bench first fills every address by write bursts. It then reads four-beat bursts from every start address in both linear and interleaved order, which tells a wrong beat order or a wrong kept upper field apart from correct wrapping. A write to one address followed directly by a read of the same address, repeated for all sixteen lane masks, separates correct forwarding from the pending register from stale array data and from lane-mask errors. A deterministic pseudo-random mix of back-to-back reads and writes, a sweep over all eight chip-enable combinations, advances after a deselected load, stalls in the middle of a burst, and toggling out_en during read and write data phases cover selection, hold and bus release.

// File: rtl/psr_pkg.sv
package psr_pkg;
    localparam int LANE_W = 9;

    typedef enum logic [1:0] {OP_NOP, OP_RD, OP_WR} op_e;
    typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_WRITE} bst_e;

    // Low two address bits for beat k of a four-beat burst
    function automatic logic [1:0] beat_lo(input logic [1:0] start,
                                           input logic [1:0] k,
                                           input logic ilv);
        return ilv ? (start ^ k) : (start + k);
    endfunction
endpackage

// File: rtl/psr_burst_ctrl.sv
module psr_burst_ctrl
    import psr_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic              adv_load,
    input  logic              wr_en,
    input  logic [LANES-1:0]  byte_sel,
    input  logic              chip_sel,
    input  logic              burst_ilv,
    output op_e               s1_op,
    output logic [ADDR_W-1:0] s1_addr,
    output logic [LANES-1:0]  s1_be,
    output bst_e              state_o
);
    bst_e              state, state_n;
    logic [ADDR_W-1:0] base, base_n, addr_n;
    logic [1:0]        cnt, cnt_n;
    op_e               op_n;

    always_comb begin
        state_n = state;
        base_n  = base;
        cnt_n   = cnt;
        op_n    = OP_NOP;
        addr_n  = addr;
        if (!adv_load) begin
            base_n = addr;
            cnt_n  = 2'd0;
            if (chip_sel) begin
                if (wr_en) begin
                    op_n    = OP_WR;
                    state_n = ST_WRITE;
                end else begin
                    op_n    = OP_RD;
                    state_n = ST_READ;
                end
            end else begin
                state_n = ST_IDLE;
            end
        end else begin
            cnt_n  = cnt + 2'd1;
            addr_n = {base[ADDR_W-1:2], beat_lo(base[1:0], cnt_n, burst_ilv)};
            unique case (state)
                ST_IDLE:  op_n = OP_NOP;
                ST_READ:  op_n = OP_RD;
                ST_WRITE: op_n = OP_WR;
                default:  op_n = OP_NOP;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            base  <= '0;
            cnt   <= 2'd0;
        end else if (clk_en) begin
            state <= state_n;
            base  <= base_n;
            cnt   <= cnt_n;
        end
    end

    // Command stage output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_op   <= OP_NOP;
            s1_addr <= '0;
            s1_be   <= '0;
        end else if (clk_en) begin
            s1_op   <= op_n;
            s1_addr <= addr_n;
            s1_be   <= byte_sel;
        end
    end

    assign state_o = state;
endmodule

// File: rtl/psr_core.sv
module psr_core
    import psr_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clk_en,
    input  op_e                       s1_op,
    input  logic [ADDR_W-1:0]         s1_addr,
    input  logic [LANES-1:0]          s1_be,
    input  logic [LANES*LANE_W-1:0]   din,
    output op_e                       s2_op,
    output logic [LANES*LANE_W-1:0]   dout_q,
    output logic                      drive_q
);
    localparam int W     = LANES * LANE_W;
    localparam int DEPTH = 1 << ADDR_W;

    logic [W-1:0]      mem [DEPTH];
    logic [ADDR_W-1:0] s2_addr;
    logic [LANES-1:0]  s2_be;
    logic              pend_valid;
    logic [ADDR_W-1:0] pend_addr;
    logic [LANES-1:0]  pend_be;
    logic [W-1:0]      pend_data;
    logic [W-1:0]      rd_word, cm_word, fwd_word, commit_word;
    logic              hit;

    assign rd_word = mem[s2_addr];
    assign cm_word = mem[pend_addr];
    assign hit     = pend_valid && (pend_addr == s2_addr);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign fwd_word[i*LANE_W +: LANE_W] = (hit && pend_be[i]) ?
            pend_data[i*LANE_W +: LANE_W] : rd_word[i*LANE_W +: LANE_W];
        assign commit_word[i*LANE_W +: LANE_W] = pend_be[i] ?
            pend_data[i*LANE_W +: LANE_W] : cm_word[i*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s2_op      <= OP_NOP;
            s2_addr    <= '0;
            s2_be      <= '0;
            pend_valid <= 1'b0;
            pend_addr  <= '0;
            pend_be    <= '0;
            pend_data  <= '0;
            dout_q     <= '0;
            drive_q    <= 1'b0;
        end else if (clk_en) begin
            s2_op   <= s1_op;
            s2_addr <= s1_addr;
            s2_be   <= s1_be;
            unique case (s2_op)
                OP_RD: begin
                    dout_q  <= fwd_word;
                    drive_q <= 1'b1;
                end
                OP_WR: begin
                    pend_valid <= 1'b1;
                    pend_addr  <= s2_addr;
                    pend_be    <= s2_be;
                    pend_data  <= din;
                    drive_q    <= 1'b0;
                end
                default: drive_q <= 1'b0;
            endcase
        end
    end

    // Late write: the older pending entry retires when a new write lands
    always_ff @(posedge clk) begin
        if (clk_en && rst_n && s2_op == OP_WR && pend_valid)
            mem[pend_addr] <= commit_word;
    end
endmodule

// File: rtl/pipe_burst_sram.sv
module pipe_burst_sram
    import psr_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clk_en,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    adv_load,
    input  logic                    wr_en,
    input  logic [LANES-1:0]        byte_sel,
    input  logic                    sel0_n,
    input  logic                    sel1,
    input  logic                    sel2_n,
    input  logic                    burst_ilv,
    input  logic                    out_en,
    input  logic [LANES*LANE_W-1:0] din,
    output logic [LANES*LANE_W-1:0] dout,
    output logic                    dout_drive
);
    op_e               s1_op, s2_op;
    logic [ADDR_W-1:0] s1_addr;
    logic [LANES-1:0]  s1_be;
    bst_e              ctl_state;
    logic              drive_q;
    logic              chip_sel;

    assign chip_sel = !sel0_n && sel1 && !sel2_n;

    psr_burst_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .addr(addr),
        .adv_load(adv_load), .wr_en(wr_en), .byte_sel(byte_sel),
        .chip_sel(chip_sel), .burst_ilv(burst_ilv),
        .s1_op(s1_op), .s1_addr(s1_addr), .s1_be(s1_be), .state_o(ctl_state)
    );

    psr_core #(.ADDR_W(ADDR_W), .LANES(LANES)) u_core (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en),
        .s1_op(s1_op), .s1_addr(s1_addr), .s1_be(s1_be), .din(din),
        .s2_op(s2_op), .dout_q(dout), .drive_q(drive_q)
    );

    assign dout_drive = out_en && drive_q;
endmodule

// File: rtl/pipe_burst_sram_chk.sv
module pipe_burst_sram_chk
    import psr_pkg::*;
#(
    parameter int W = 36
) (
    input logic         clk,
    input logic         rst_n,
    input logic         clk_en,
    input logic         adv_load,
    input logic         out_en,
    input logic [W-1:0] dout,
    input logic         dout_drive,
    input op_e          s1_op,
    input op_e          s2_op,
    input bst_e         ctl_state
);
    AST_WR_PHASE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && s2_op == OP_WR) |=> !dout_drive); // R7

    AST_RD_PHASE_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && s2_op == OP_RD) |=> (dout_drive || !out_en)); // R1

    AST_PIPE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en |=> (s2_op == $past(s1_op))); // R1

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |=> ($stable(dout) && $stable(s2_op) && $stable(s1_op) && $stable(ctl_state))); // R5

    AST_ADV_AFTER_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && adv_load && ctl_state == ST_IDLE) |=> (s1_op == OP_NOP)); // R11

    always_comb begin
        if (rst_n && !out_en)
            AST_OE_GATE: assert (!dout_drive); // R6
    end
endmodule

bind pipe_burst_sram pipe_burst_sram_chk #(.W(LANES*psr_pkg::LANE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .adv_load(adv_load),
    .out_en(out_en), .dout(dout), .dout_drive(dout_drive),
    .s1_op(s1_op), .s2_op(s2_op), .ctl_state(ctl_state)
);

// File: tb/pipe_burst_sram_bench.sv
`timescale 1ns/1ps
module pipe_burst_sram_bench;
    localparam int AW = 6;
    localparam int NL = 4;
    localparam int W  = NL * 9;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clk_en = 1'b1;
    logic [AW-1:0] addr = '0;
    logic          adv_load = 1'b0;
    logic          wr_en = 1'b0;
    logic [NL-1:0] byte_sel = '0;
    logic          sel0_n = 1'b1, sel1 = 1'b0, sel2_n = 1'b1;
    logic          burst_ilv = 1'b0;
    logic          out_en = 1'b1;
    logic [W-1:0]  din = '0;
    logic [W-1:0]  dout;
    logic          dout_drive;

    pipe_burst_sram #(.ADDR_W(AW), .LANES(NL)) u_pipe_burst_sram (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .addr(addr),
        .adv_load(adv_load), .wr_en(wr_en), .byte_sel(byte_sel),
        .sel0_n(sel0_n), .sel1(sel1), .sel2_n(sel2_n),
        .burst_ilv(burst_ilv), .out_en(out_en), .din(din),
        .dout(dout), .dout_drive(dout_drive)
    );

    always #4 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Bench model: op codes 0 none, 1 read, 2 write
    logic [W-1:0]  ref_mem [DEPTH];
    int            m_st = 0;
    logic [AW-1:0] m_base = '0;
    logic [1:0]    m_cnt = 2'd0;
    int            p1_op = 0, p2_op = 0;
    logic [AW-1:0] p1_addr = '0, p2_addr = '0;
    logic [NL-1:0] p1_be = '0, p2_be = '0;
    logic [8:0]    wseq = 9'd0;
    logic [15:0]   lfsr = 16'hACE1;

    task automatic check_w(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic check_b(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%b exp=%b", tag, act, exp);
        end
    endtask

    function automatic logic [W-1:0] mkdata(input logic [8:0] s);
        return {s + 9'd3, s + 9'd2, s + 9'd1, s ^ 9'h155};
    endfunction

    // One enabled clock with a command; checks the data phase that completes
    task automatic issue(input string tag, input logic adv, input logic we,
                         input logic [AW-1:0] a, input logic [NL-1:0] be,
                         input logic [2:0] cs);
        int            nop;
        logic [AW-1:0] naddr;
        logic [1:0]    lo;
        clk_en = 1'b1; adv_load = adv; wr_en = we; addr = a; byte_sel = be;
        {sel0_n, sel1, sel2_n} = cs;
        if (p2_op == 2) begin
            wseq = wseq + 9'd7;
            din = mkdata(wseq);
        end else begin
            din = ~mkdata(wseq);
        end
        if (!adv) begin
            nop = (cs == 3'b010) ? (we ? 2 : 1) : 0;
            naddr = a; m_st = nop; m_base = a; m_cnt = 2'd0;
        end else begin
            m_cnt = m_cnt + 2'd1;
            lo = burst_ilv ? (m_base[1:0] ^ m_cnt) : (m_base[1:0] + m_cnt);
            naddr = {m_base[AW-1:2], lo};
            nop = m_st;
        end
        @(posedge clk); #1;
        if (p2_op == 1) begin
            check_w(tag, dout, ref_mem[p2_addr]);
            check_b(tag, dout_drive, out_en);
        end else begin
            if (p2_op == 2)
                for (int i = 0; i < NL; i++)
                    if (p2_be[i]) ref_mem[p2_addr][i*9 +: 9] = din[i*9 +: 9];
            check_b(tag, dout_drive, 1'b0);
        end
        p2_op = p1_op; p2_addr = p1_addr; p2_be = p1_be;
        p1_op = nop;   p1_addr = naddr;   p1_be = be;
    endtask

    task automatic flush(input string tag);
        issue(tag, 1'b0, 1'b0, '0, '0, 3'b111);
        issue(tag, 1'b0, 1'b0, '0, '0, 3'b111);
    endtask

    task automatic stall(input string tag);
        logic [W-1:0] d0;
        logic         v0;
        d0 = dout; v0 = dout_drive;
        clk_en = 1'b0; addr = ~addr; wr_en = ~wr_en; adv_load = ~adv_load;
        din = ~din; {sel0_n, sel1, sel2_n} = 3'b010;
        @(posedge clk); #1;
        check_w(tag, dout, d0);
        check_b(tag, dout_drive, v0);
    endtask

    task automatic step_lfsr();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog act=running exp=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check_w("R12", dout, '0);
        check_b("R12", dout_drive, 1'b0);
        rst_n = 1'b1;
        @(posedge clk); #1;

        // R2: fill every word with linear write bursts
        burst_ilv = 1'b0;
        for (int a = 0; a < DEPTH; a += 4) begin
            issue("R2", 1'b0, 1'b1, AW'(a), 4'hF, 3'b010);
            for (int k = 0; k < 3; k++) issue("R2", 1'b1, 1'b0, '0, 4'hF, 3'b111);
        end
        flush("R2");
        // Retire the last pending write with one more write
        issue("R2", 1'b0, 1'b1, 6'd0, 4'hF, 3'b010);
        flush("R2");

        // R1: isolated reads
        for (int a = 0; a < 8; a++) begin
            issue("R1", 1'b0, 1'b0, AW'(a * 9), 4'h0, 3'b010);
            flush("R1");
        end

        // R9: linear bursts from every start
        for (int a = 0; a < DEPTH; a++) begin
            issue("R9", 1'b0, 1'b0, AW'(a), 4'h0, 3'b010);
            for (int k = 0; k < 3; k++) issue("R9", 1'b1, 1'b1, AW'(a + 17), 4'h0, 3'b101);
        end
        flush("R9");

        // R10: interleaved bursts from every start
        burst_ilv = 1'b1;
        for (int a = 0; a < DEPTH; a++) begin
            issue("R10", 1'b0, 1'b0, AW'(a), 4'h0, 3'b010);
            for (int k = 0; k < 3; k++) issue("R10", 1'b1, 1'b0, '0, 4'h0, 3'b010);
        end
        flush("R10");
        // Interleaved write burst then read back
        issue("R10", 1'b0, 1'b1, 6'd22, 4'hF, 3'b010);
        for (int k = 0; k < 3; k++) issue("R10", 1'b1, 1'b0, '0, 4'hF, 3'b010);
        issue("R10", 1'b0, 1'b0, 6'd21, 4'h0, 3'b010);
        for (int k = 0; k < 3; k++) issue("R10", 1'b1, 1'b0, '0, 4'h0, 3'b010);
        flush("R10");
        burst_ilv = 1'b0;

        // R3: every lane mask, write then read of the same word back to back
        for (int m = 0; m < 16; m++) begin
            issue("R3", 1'b0, 1'b1, 6'd5, 4'(m), 3'b010);
            issue("R3", 1'b0, 1'b0, 6'd5, 4'h0, 3'b010);
        end
        flush("R3");

        // R8: pseudo-random back-to-back mix on a few addresses
        for (int n = 0; n < 400; n++) begin
            step_lfsr();
            issue("R8", 1'b0, lfsr[0], {3'b110, lfsr[3:1]}, lfsr[7:4], 3'b010);
        end
        flush("R8");

        // R7: write data phases with out_en high between reads
        out_en = 1'b1;
        for (int n = 0; n < 6; n++) begin
            issue("R7", 1'b0, 1'b1, AW'(30 + n), 4'hF, 3'b010);
            issue("R7", 1'b0, 1'b0, AW'(30 + n), 4'h0, 3'b010);
        end
        flush("R7");

        // R4: all chip-enable combinations on writes, then read back
        for (int c = 0; c < 8; c++)
            issue("R4", 1'b0, 1'b1, AW'(40 + c), 4'hF, 3'(c));
        for (int c = 0; c < 8; c++)
            issue("R4", 1'b0, 1'b0, AW'(40 + c), 4'h0, 3'(c));
        flush("R4");
        for (int c = 0; c < 8; c++)
            issue("R4", 1'b0, 1'b0, AW'(40 + c), 4'h0, 3'b010);
        flush("R4");

        // R11: advances after deselect do nothing; advances repeat write type
        issue("R11", 1'b0, 1'b1, 6'd48, 4'hF, 3'b110);
        for (int k = 0; k < 3; k++) issue("R11", 1'b1, 1'b1, 6'd48, 4'hF, 3'b010);
        issue("R11", 1'b0, 1'b1, 6'd12, 4'hF, 3'b010);
        for (int k = 0; k < 3; k++) issue("R11", 1'b1, 1'b0, 6'd0, 4'hF, 3'b111);
        issue("R11", 1'b0, 1'b0, 6'd48, 4'h0, 3'b010);
        for (int k = 0; k < 3; k++) issue("R11", 1'b1, 1'b1, 6'd0, 4'h0, 3'b000);
        issue("R11", 1'b0, 1'b0, 6'd12, 4'h0, 3'b010);
        for (int k = 0; k < 3; k++) issue("R11", 1'b1, 1'b0, 6'd0, 4'h0, 3'b010);
        flush("R11");

        // R5: stalls inside bursts of both kinds
        issue("R5", 1'b0, 1'b1, 6'd56, 4'hF, 3'b010);
        stall("R5");
        issue("R5", 1'b1, 1'b0, '0, 4'hF, 3'b111);
        stall("R5"); stall("R5");
        issue("R5", 1'b1, 1'b0, '0, 4'hF, 3'b111);
        issue("R5", 1'b0, 1'b0, 6'd56, 4'h0, 3'b010);
        stall("R5");
        issue("R5", 1'b1, 1'b0, '0, 4'h0, 3'b111);
        stall("R5");
        issue("R5", 1'b1, 1'b0, '0, 4'h0, 3'b111);
        stall("R5"); stall("R5");
        issue("R5", 1'b1, 1'b0, '0, 4'h0, 3'b111);
        flush("R5");

        // R6: out_en gates the flag without a clock edge
        issue("R6", 1'b0, 1'b0, 6'd3, 4'h0, 3'b010);
        issue("R6", 1'b0, 1'b0, 6'd4, 4'h0, 3'b010);
        issue("R6", 1'b0, 1'b0, 6'd5, 4'h0, 3'b111);
        #1 out_en = 1'b0; #1;
        check_b("R6", dout_drive, 1'b0);
        out_en = 1'b1; #1;
        check_b("R6", dout_drive, 1'b1);
        out_en = 1'b0;
        issue("R6", 1'b0, 1'b0, 6'd6, 4'h0, 3'b010);
        issue("R6", 1'b0, 1'b0, 6'd7, 4'h0, 3'b010);
        flush("R6");
        out_en = 1'b1;
        flush("R6");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule